// File: doc/BRIEF.md
# 40-Column Display Address Generator

This block produces display memory addresses for a bitmap screen that is 40 character cells wide. It advances once for each character-cell fetch slot. A horizontal cell counter runs through 64 slots per scanline, and a vertical pixel-line counter runs through 312 lines per frame. For every visible cell the block presents a bitmap byte address and the matching attribute byte address together with an address-valid strobe. During border time the border flag is raised and no address is driven.

A cell's offset within its screen block is its character row times 40 plus its column. The multiply is never built. A running character-position counter steps once per visible cell. At each new pixel line it reloads from the base of the current character row. That base grows by 40 after the eighth pixel line of a character row, and it returns to zero at frame start. The pixel lines inside one character row lie 1024 bytes apart in the bitmap region, and the attribute region holds one byte per cell.

The outputs are combinational from the counter state. A downstream fetch engine samples `bmp_addr`, `atr_addr` and `addr_valid` in the same cycle it asserts `slot_en`. The counters step at the rising edge that ends that slot.

Top module: `vaddr40_gen`

## Requirements
- R1: After reset the counters sit at column 0, line 0. The first slot shows bmp_addr 0x4000, atr_addr 0x6000, addr_valid 1 and border 0.
- R2: The column advances by one only at a rising edge where slot_en is 1. When slot_en is 0, all outputs hold their values into the next cycle.
- R3: In columns 40 to 63 of any line, border is 1, addr_valid is 0, and bmp_addr and atr_addr are 0.
- R4: The pixel line advances when the column steps from 63 to 0. Lines 200 to 311 are vertical border, with the outputs as in R3.
- R5: For a visible cell at line L and column C, bmp_addr = 0x4000 + (L mod 8)·1024 + (L div 8)·40 + C.
- R6: For a visible cell, atr_addr = 0x6000 + (L div 8)·40 + C. The final cell (line 199, column 39) gives 0x63E7.
- R7: While addr_valid is 1, the low ten bits of bmp_addr are below 1000, so offsets 1000 to 1023 of each 1024-byte block are never issued.
- R8: After line 311 the line counter returns to 0, and the next slot shows 0x4000 / 0x6000 again.
- R9: Each pixel line of a character row starts again at that row's base. For example, line 1, column 0 gives bmp_addr 0x4400 and atr_addr 0x6000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_en | input | 1 | Advances the counters at this edge (one character-cell slot) |
| bmp_addr | output | 16 | Bitmap byte address of the current cell, 0 in border |
| atr_addr | output | 16 | Attribute byte address of the current cell, 0 in border |
| border | output | 1 | Current slot lies in horizontal or vertical border |
| addr_valid | output | 1 | Addresses are meaningful this slot |

## Verification
Two pieces of logic can act in the same cycle. At column 63 the horizontal wrap causes a line step, and on the eighth pixel line of a character row the same step also advances the row base, which the position counter must pick up immediately. The second collision occurs on line 311, where the frame wrap clears the base and the position together with the line step. The bench provokes both by running whole frames without gaps and also with periodic idle slots. It judges each collision by the first slot after it: the addresses of the new line must start exactly at the new row base, or at 0x4000 after a frame.

// File: rtl/vag_pkg.sv
package vag_pkg;

  // Vertical step events produced once per line change.
  typedef struct packed {
    logic line_step;   // column wrapped, line moves on
    logic row_end;     // last pixel line of a visible character row is ending
    logic frame_wrap;  // last line of the frame is ending
  } vstep_t;

endpackage

// File: rtl/vag_rst_sync.sv
module vag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/vag_hcount.sv
module vag_hcount #(
  parameter int HTOTAL = 64,
  parameter int COLS   = 40,
  parameter int COL_W  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  output logic hborder,
  output logic wrap
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(HTOTAL - 1);

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_d;

  // next-state
  always_comb begin
    col_d = col_q;
    if (col_q == COL_LAST) begin
      col_d = '0;
    end else begin
      col_d = col_q + 1'b1;
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (slot_en) begin
      col_q <= col_d;
    end
  end

  assign wrap = slot_en & (col_q == COL_LAST);

  // Border decode: cheap gate form for the 40-of-64 case, comparator otherwise.
  generate
    if (HTOTAL == 64 && COLS == 40) begin : g_gate
      assign hborder = col_q[5] & (col_q[4] | col_q[3]);
    end else begin : g_cmp
      localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);
      assign hborder = (col_q >= COL_LIM);
    end
  endgenerate

  // R2: no slot, no movement
  a_r2_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(col_q));

  // R2: a slot moves the column by exactly one
  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && col_q != COL_LAST) |=> (col_q == $past(col_q) + 1'b1));

  // R4: a wrap lands on column 0
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (col_q == '0));

endmodule

// File: rtl/vag_vcount.sv
module vag_vcount
  import vag_pkg::*;
#(
  parameter int VTOTAL       = 312,
  parameter int ACTIVE_LINES = 200,
  parameter int ROW_LINES    = 8,
  parameter int LINE_W       = 9,
  parameter int SUB_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  output logic [SUB_W-1:0] sub,
  output logic             vactive,
  output vstep_t           steps
);

  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(VTOTAL - 1);
  localparam logic [LINE_W-1:0] ACT_LIM   = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] ACT_LAST  = LINE_W'(ACTIVE_LINES - 1);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(ROW_LINES - 1);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    line_d = line_q;
    if (line_q == LINE_LAST) begin
      line_d = '0;
    end else begin
      line_d = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (wrap) begin
      line_q <= line_d;
    end
  end

  assign sub     = line_q[SUB_W-1:0];
  assign vactive = (line_q < ACT_LIM);

  always_comb begin
    steps.line_step  = wrap;
    steps.row_end    = wrap & (sub == SUB_LAST) & (line_q < ACT_LAST);
    steps.frame_wrap = wrap & (line_q == LINE_LAST);
  end

  // R4: line steps by one on a wrap, or returns to 0 at frame end
  a_r4_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && line_q != LINE_LAST) |=> (line_q == $past(line_q) + 1'b1));

  // R4: line is frozen between wraps
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(line_q));

  // R8: frame end brings the line back to 0
  a_r8_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    steps.frame_wrap |=> (line_q == '0));

endmodule

// File: rtl/vag_charpos.sv
module vag_charpos
  import vag_pkg::*;
#(
  parameter int COLS  = 40,
  parameter int ROWS  = 25,
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_en,
  input  logic             cell_active,
  input  vstep_t           steps,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] COLS_P  = POS_W'(COLS);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(COLS * ROWS);

  logic [POS_W-1:0] base_q, base_d;
  logic [POS_W-1:0] pos_q,  pos_d;

  // next-state: frame restart beats line reload beats cell increment
  always_comb begin
    base_d = base_q;
    pos_d  = pos_q;
    if (steps.frame_wrap) begin
      base_d = '0;
      pos_d  = '0;
    end else if (steps.line_step) begin
      if (steps.row_end) begin
        base_d = base_q + COLS_P;
      end
      pos_d = base_d;
    end else if (cell_active) begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
    end else if (slot_en) begin
      base_q <= base_d;
      pos_q  <= pos_d;
    end
  end

  assign pos = pos_q;

  // R8: frame restart clears both base and position
  a_r8_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    steps.frame_wrap |=> (pos_q == '0 && base_q == '0));

  // R9: a plain line step restarts at the unchanged row base
  a_r9_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (steps.line_step && !steps.row_end && !steps.frame_wrap)
      |=> (pos_q == $past(base_q)));

  // R7: the running position never passes the screen size
  a_r7_pos_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_MAX);

endmodule

// File: rtl/vaddr40_gen.sv
module vaddr40_gen #(
  parameter int              COLS         = 40,
  parameter int              HTOTAL       = 64,
  parameter int              ROW_LINES    = 8,
  parameter int              ROWS         = 25,
  parameter int              VTOTAL       = 312,
  parameter int              LINE_STRIDE  = 1024,
  parameter int              ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] BMP_BASE   = 16'h4000,
  parameter logic [ADDR_W-1:0] ATR_BASE   = 16'h6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  output logic [ADDR_W-1:0] bmp_addr,
  output logic [ADDR_W-1:0] atr_addr,
  output logic              border,
  output logic              addr_valid
);

  import vag_pkg::*;

  localparam int ACTIVE_LINES = ROWS * ROW_LINES;
  localparam int COL_W        = $clog2(HTOTAL);
  localparam int LINE_W       = $clog2(VTOTAL);
  localparam int SUB_W        = $clog2(ROW_LINES);
  localparam int POS_W        = $clog2(COLS * ROWS + 1);
  localparam int STRIDE_SH    = $clog2(LINE_STRIDE);
  localparam logic [ADDR_W-1:0] ATR_LAST  = ATR_BASE + ADDR_W'(COLS * ROWS - 1);
  localparam logic [STRIDE_SH-1:0] OFF_LIM = STRIDE_SH'(COLS * ROWS);

  logic             rst_sync_n;
  logic             hborder;
  logic             wrap;
  logic [SUB_W-1:0] sub;
  logic             vactive;
  vstep_t           steps;
  logic [POS_W-1:0] pos;
  logic             cell_active;
  logic [ADDR_W-1:0] pos_ext;
  logic [ADDR_W-1:0] sub_off;

  vag_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vag_hcount #(
    .HTOTAL (HTOTAL),
    .COLS   (COLS),
    .COL_W  (COL_W)
  ) u_hcount (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .slot_en (slot_en),
    .hborder (hborder),
    .wrap    (wrap)
  );

  vag_vcount #(
    .VTOTAL       (VTOTAL),
    .ACTIVE_LINES (ACTIVE_LINES),
    .ROW_LINES    (ROW_LINES),
    .LINE_W       (LINE_W),
    .SUB_W        (SUB_W)
  ) u_vcount (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wrap    (wrap),
    .sub     (sub),
    .vactive (vactive),
    .steps   (steps)
  );

  assign cell_active = ~hborder & vactive;

  vag_charpos #(
    .COLS  (COLS),
    .ROWS  (ROWS),
    .POS_W (POS_W)
  ) u_charpos (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .slot_en     (slot_en),
    .cell_active (cell_active),
    .steps       (steps),
    .pos         (pos)
  );

  // address composition
  always_comb begin
    pos_ext    = ADDR_W'(pos);
    sub_off    = ADDR_W'(sub) << STRIDE_SH;
    border     = ~cell_active;
    addr_valid = cell_active;
    if (cell_active) begin
      bmp_addr = BMP_BASE + sub_off + pos_ext;
      atr_addr = ATR_BASE + pos_ext;
    end else begin
      bmp_addr = '0;
      atr_addr = '0;
    end
  end

  // R3: border slots issue nothing
  a_r3_border_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    border |-> (!addr_valid && bmp_addr == '0 && atr_addr == '0));

  // R6: attribute address stays inside its window
  a_r6_attr_window: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_valid |-> (atr_addr >= ATR_BASE && atr_addr <= ATR_LAST));

  // R5: bitmap and attribute share the same cell offset
  a_r5_offset_pair: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_valid |-> (bmp_addr[STRIDE_SH-1:0] == STRIDE_SH'(atr_addr - ATR_BASE)));

  // R7: the unused tail of each pixel-line block is never touched
  a_r7_tail_unused: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_valid |-> (bmp_addr[STRIDE_SH-1:0] < OFF_LIM));

endmodule

// File: tb/vaddr40_gen_bench.sv
module vaddr40_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_en;
  logic [15:0] bmp_addr;
  logic [15:0] atr_addr;
  logic        border;
  logic        addr_valid;

  always #5 clk = ~clk;

  vaddr40_gen u_vaddr40_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_en    (slot_en),
    .bmp_addr   (bmp_addr),
    .atr_addr   (atr_addr),
    .border     (border),
    .addr_valid (addr_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int mcol, mline, frames;
  bit first;

  // scoreboard
  logic [15:0] q_bmp[$];
  logic [15:0] q_atr[$];
  logic        q_brd[$];
  logic        q_val[$];
  string       q_tag[$];

  task automatic push_slot(input bit en);
    bit vis;
    int p;
    logic [15:0] eb, ea;
    string tag;
    vis = (mcol < 40) && (mline < 200);
    p   = (mline / 8) * 40 + mcol;
    eb  = vis ? 16'(16'h4000 + (mline % 8) * 1024 + p) : 16'h0000;
    ea  = vis ? 16'(16'h6000 + p) : 16'h0000;
    if (first && en)                              tag = "R1";
    else if (!en)                                 tag = "R2";
    else if (mline >= 200)                        tag = "R4";
    else if (mcol >= 40)                          tag = "R3";
    else if (mline == 0 && mcol == 0 && frames > 0) tag = "R8";
    else if (mline == 199 && mcol == 39)          tag = "R6";
    else if ((mline % 8) != 0 && mcol == 0)       tag = "R9";
    else                                          tag = "R5";
    if (en) first = 1'b0;
    q_bmp.push_back(eb);
    q_atr.push_back(ea);
    q_brd.push_back(!vis);
    q_val.push_back(vis);
    q_tag.push_back(tag);
    if (en) begin
      mcol++;
      if (mcol == 64) begin
        mcol = 0;
        mline++;
        if (mline == 312) begin
          mline = 0;
          frames++;
        end
      end
    end
  endtask

  // drive n slots; every idle_every-th slot is left idle (0 = never)
  task automatic drive(input int n, input int idle_every);
    for (int i = 0; i < n; i++) begin
      bit en;
      @(negedge clk);
      en = !(idle_every > 0 && (i % idle_every) == idle_every - 1);
      slot_en = en;
      push_slot(en);
    end
    @(negedge clk);
    slot_en = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    slot_en = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mcol  = 0;
    mline = 0;
    first = 1'b1;
  endtask

  // monitor: samples between the falling and the rising edge
  always @(negedge clk) begin
    #2;
    if (q_bmp.size() > 0) begin
      logic [15:0] eb, ea;
      logic        ebr, ev;
      string       tg;
      eb = q_bmp.pop_front();
      ea = q_atr.pop_front();
      ebr = q_brd.pop_front();
      ev = q_val.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (bmp_addr !== eb || atr_addr !== ea || border !== ebr || addr_valid !== ev) begin
        fails++;
        $display("FAIL %s: bmp=%h atr=%h brd=%b val=%b expected bmp=%h atr=%h brd=%b val=%b",
                 tg, bmp_addr, atr_addr, border, addr_valid, eb, ea, ebr, ev);
      end
      if (addr_valid === 1'b1) begin
        checks++;
        if (bmp_addr[9:0] >= 10'd1000) begin
          fails++;
          $display("FAIL R7: bmp offset=%0d expected below 1000", bmp_addr[9:0]);
        end
      end
    end
  end

  initial begin
    rst_n   = 1'b0;
    slot_en = 1'b0;
    mcol = 0; mline = 0; frames = 0; first = 1'b1;
    apply_reset();
    drive(1, 0);              // R1 first slot
    drive(3, 1);              // R2 idle slots hold
    drive(64 * 312, 97);      // full frame with gaps: R3 R4 R5 R6 R9
    drive(64 * 312, 0);       // back-to-back frame, crossing R8
    drive(500, 0);
    apply_reset();            // mid-frame reset, R1 again
    drive(300, 5);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule